// File: doc/BRIEF.md
# Scrolling Pseudorandom Starfield Generator

This block produces a field of stars for a raster display, one pixel per enabled clock. A right-shifting linear feedback shift register, with its taps applied as a Galois-style XOR, advances by one step for every pixel. The state of the register at each pixel decides whether a star is lit there and how bright it is. The register is placed beside the display timing logic. Its enable follows the pixels that the layer should cover.

A frame position counter sits next to the register and reloads the register's seed each time the counter returns to zero. The counter's period is the full frame size (visible area plus blanking) plus a signed offset. When the offset is negative, the sequence restarts a little early in every frame, so each star appears that many pixels further left in the next frame. When the offset is positive, the field drifts right. Several instances with different offsets, seeds and density masks can be stacked to form parallax layers.

A star is present when every bit of the register, after it is ORed with a density mask, is one. A mask with more ones therefore gives a denser field. The low eight bits of the register give the star's brightness.

Top module: `lfsr_starfield`

## Requirements
- R1: On each advance the register shifts right by one position with a zero entering at the top. If the bit that left at position 0 was 1, the result is XORed with the tap pattern. With an 8-bit register, taps 8'hB8 and value 169, the next values are 236, then 118, then 59.
- R2: The frame counter counts enabled clocks from 0 up to FRAME_W*FRAME_H+DRIFT-1 and then returns to 0. The star pattern therefore repeats every FRAME_W*FRAME_H+DRIFT enabled pixels.
- R3: On an enabled clock at which the frame counter is 0, the register loads SEED instead of advancing. At counter position 1 the output therefore shows the seed, and positions after that show successive advances of it.
- R4: `star_on` is 1 exactly when the register ORed with DENSITY_MASK has every bit set.
- R5: `star_level` equals bits 7:0 of the register.
- R6: While `en` is 0, neither the frame counter nor the register changes, and both outputs hold their values.
- R7: A synchronous active-high `rst` sets the frame counter to 0 and the register to SEED, whatever the state of `en`.
- R8: With drift value DRIFT, the output at pixel t plus FRAME_W*FRAME_H equals the output at pixel t minus DRIFT. For a negative DRIFT, this moves the field left by |DRIFT| pixels per frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Advances the counter and the register by one pixel |
| star_on | output | 1 | A star is present at the current pixel |
| star_level | output | 8 | Brightness of the current pixel |

## Verification
Both outputs are combinational decodes of registered state. A change on `en` or `rst` therefore appears on the outputs after exactly one rising edge, and the seed reload makes the seed visible one enabled edge after the counter passes zero. The bench drives inputs and samples at falling edges. The value seen at each falling edge describes the pixel whose index equals the number of enabled edges since reset. Expected sequences are indexed on that count, the period and the drift displacement are compared across recorded samples, and the enable-hold rows sample the same falling edge pattern with `en` low.

// File: rtl/starfield_pkg.sv
package starfield_pkg;

  // One Galois step on a right-shifting register; unused upper bits stay zero.
  function automatic logic [63:0] lfsr_advance(input logic [63:0] cur,
                                               input logic [63:0] taps);
    logic [63:0] shifted;
    shifted = cur >> 1;
    return cur[0] ? (shifted ^ taps) : shifted;
  endfunction

  // Length of one pattern cycle in enabled pixels.
  function automatic int pattern_period(input int width, input int height,
                                        input int drift);
    return width * height + drift;
  endfunction

  // Counter width able to hold the last position of the cycle.
  function automatic int count_bits(input int period);
    return (period <= 2) ? 1 : $clog2(period);
  endfunction

endpackage

// File: rtl/sf_frame_counter.sv
module sf_frame_counter
  import starfield_pkg::*;
#(
  parameter int FRAME_W = 800,
  parameter int FRAME_H = 525,
  parameter int DRIFT   = -1
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  output logic frame_zero
);
  localparam int PERIOD = pattern_period(FRAME_W, FRAME_H, DRIFT);
  localparam int CNTW   = count_bits(PERIOD);
  localparam logic [CNTW-1:0] LAST = CNTW'(PERIOD - 1);

  logic [CNTW-1:0] pos_q;
  logic            at_last;

  assign at_last    = (pos_q == LAST);
  assign frame_zero = (pos_q == '0);

  always_ff @(posedge clk) begin
    if (rst)          pos_q <= '0;
    else if (en) begin
      if (at_last)    pos_q <= '0;
      else            pos_q <= pos_q + 1'b1;
    end
  end

  assert_wrap_R2: assert property (@(posedge clk) disable iff (rst)
    (en && at_last) |=> frame_zero);

  assert_count_up_R2: assert property (@(posedge clk) disable iff (rst)
    (en && !at_last) |=> (pos_q == $past(pos_q) + 1'b1));

  assert_count_hold_R6: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(pos_q));

endmodule

// File: rtl/sf_lfsr.sv
module sf_lfsr
  import starfield_pkg::*;
#(
  parameter int              LEN  = 21,
  parameter logic [LEN-1:0]  TAPS = 21'h140000,
  parameter logic [LEN-1:0]  SEED = '1
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           en,
  input  logic           load,
  output logic [LEN-1:0] state
);
  logic [63:0]    wide_next;
  logic [LEN-1:0] step_val;

  assign wide_next = lfsr_advance(64'(state), 64'(TAPS));
  assign step_val  = wide_next[LEN-1:0];

  always_ff @(posedge clk) begin
    if (rst)        state <= SEED;
    else if (en) begin
      if (load)     state <= SEED;
      else          state <= step_val;
    end
  end

  assert_seed_load_R3: assert property (@(posedge clk) disable iff (rst)
    (en && load) |=> (state == SEED));

  assert_shift_plain_R1: assert property (@(posedge clk) disable iff (rst)
    (en && !load && !state[0]) |=> (state == ($past(state) >> 1)));

  assert_shift_taps_R1: assert property (@(posedge clk) disable iff (rst)
    (en && !load && state[0]) |=> (state == (($past(state) >> 1) ^ TAPS)));

  assert_state_hold_R6: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(state));

endmodule

// File: rtl/sf_star_detect.sv
module sf_star_detect #(
  parameter int             LEN  = 21,
  parameter logic [LEN-1:0] MASK = LEN'(12'hFFF)
) (
  input  logic [LEN-1:0] state,
  output logic           star_on,
  output logic [7:0]     star_level
);
  logic [LEN-1:0] masked;

  assign masked     = state | MASK;
  assign star_on    = &masked;
  assign star_level = state[7:0];

  always_comb begin
    if (state == '1) assert_full_is_star_R4: assert (star_on);
  end

endmodule

// File: rtl/lfsr_starfield.sv
module lfsr_starfield #(
  parameter int             LEN          = 21,
  parameter logic [LEN-1:0] TAPS         = 21'h140000,
  parameter logic [LEN-1:0] SEED         = '1,
  parameter logic [LEN-1:0] DENSITY_MASK = LEN'(12'hFFF),
  parameter int             FRAME_W      = 800,
  parameter int             FRAME_H      = 525,
  parameter int             DRIFT        = -1
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       en,
  output logic       star_on,
  output logic [7:0] star_level
);
  logic           frame_zero;
  logic [LEN-1:0] sf_state;

  sf_frame_counter #(
    .FRAME_W(FRAME_W),
    .FRAME_H(FRAME_H),
    .DRIFT  (DRIFT)
  ) u_cnt (
    .clk       (clk),
    .rst       (rst),
    .en        (en),
    .frame_zero(frame_zero)
  );

  sf_lfsr #(
    .LEN (LEN),
    .TAPS(TAPS),
    .SEED(SEED)
  ) u_lfsr (
    .clk  (clk),
    .rst  (rst),
    .en   (en),
    .load (frame_zero),
    .state(sf_state)
  );

  sf_star_detect #(
    .LEN (LEN),
    .MASK(DENSITY_MASK)
  ) u_detect (
    .state     (sf_state),
    .star_on   (star_on),
    .star_level(star_level)
  );

  assert_out_hold_R6: assert property (@(posedge clk) disable iff (rst)
    !en |=> ($stable(star_level) && $stable(star_on)));

endmodule

// File: tb/tb_lfsr_starfield.sv
module tb_lfsr_starfield;
  localparam int         LEN   = 8;
  localparam logic [7:0] TAPS  = 8'hB8;
  localparam logic [7:0] SEED  = 8'd169;
  localparam logic [7:0] MASK  = 8'h1F;
  localparam int         FW    = 8;
  localparam int         FH    = 4;
  localparam int         DRIFT = -1;
  localparam int         FRAME = FW * FH;
  localparam int         PER   = FRAME + DRIFT;
  localparam int         NREC  = 100;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en  = 1'b0;
  logic       star_on;
  logic [7:0] star_level;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  lfsr_starfield #(
    .LEN(LEN), .TAPS(TAPS), .SEED(SEED), .DENSITY_MASK(MASK),
    .FRAME_W(FW), .FRAME_H(FH), .DRIFT(DRIFT)
  ) dut (
    .clk(clk), .rst(rst), .en(en),
    .star_on(star_on), .star_level(star_level)
  );

  // {expected level, expected star, en driven for the next edge}
  localparam logic [9:0] VEC [6] = '{
    {8'd169, 1'b0, 1'b1},
    {8'd169, 1'b0, 1'b1},
    {8'd236, 1'b1, 1'b0},
    {8'd236, 1'b1, 1'b1},
    {8'd118, 1'b0, 1'b1},
    {8'd59,  1'b0, 1'b0}
  };

  function automatic logic [7:0] ref_next(input logic [7:0] v);
    logic [7:0] r;
    r = {1'b0, v[7:1]};
    if (v[0]) r = r ^ TAPS;
    return r;
  endfunction

  function automatic logic ref_star(input logic [7:0] v);
    return (v | MASK) == 8'hFF;
  endfunction

  task automatic check(input bit ok, input string req,
                       input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic apply_reset();
    @(negedge clk);
    rst = 1'b1;
    en  = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  logic [7:0] rec_lvl  [NREC];
  logic       rec_star [NREC];
  logic [7:0] seq      [PER];

  initial begin
    logic [7:0] wrapval;

    // reset state, R7
    apply_reset();
    check(star_level == SEED, "R7 reset level", star_level, SEED);
    check(star_on == 1'b0, "R7 reset star", star_on, 0);

    // vector table: R1 step values, R3 seed load, R4 star, R5 level, R6 hold
    for (int i = 0; i < 6; i++) begin
      check(star_level == VEC[i][9:2], "R1/R3/R5 level", star_level, VEC[i][9:2]);
      check(star_on == VEC[i][1], "R4 star", star_on, VEC[i][1]);
      en = VEC[i][0];
      @(negedge clk);
    end
    check(star_level == 8'd59, "R6 hold after en low", star_level, 59);

    // reference sequence indexed by enabled edges since reset
    seq[0] = SEED;
    seq[1] = SEED;
    for (int k = 2; k < PER; k++) seq[k] = ref_next(seq[k-1]);
    wrapval = ref_next(seq[PER-1]);

    // continuous run
    apply_reset();
    en = 1'b1;
    for (int t = 0; t < NREC; t++) begin
      rec_lvl[t]  = star_level;
      rec_star[t] = star_on;
      @(negedge clk);
    end
    en = 1'b0;

    for (int t = 0; t < NREC; t++) begin
      logic [7:0] e;
      e = (t == 0) ? SEED : (((t % PER) == 0) ? wrapval : seq[t % PER]);
      check(rec_lvl[t] == e, "R2/R3 sequence", rec_lvl[t], e);
      check(rec_star[t] == ref_star(e), "R4 star density", rec_star[t], ref_star(e));
    end
    for (int t = 1; t + PER < NREC; t++)
      check(rec_lvl[t + PER] == rec_lvl[t], "R2 period", rec_lvl[t + PER], rec_lvl[t]);
    for (int t = 1; t + FRAME < NREC; t++)
      check(rec_lvl[t + FRAME] == rec_lvl[t - DRIFT], "R8 drift",
            rec_lvl[t + FRAME], rec_lvl[t - DRIFT]);

    // enable low over several edges, R6
    begin
      logic [7:0] held;
      held = star_level;
      repeat (5) @(negedge clk);
      check(star_level == held, "R6 long hold", star_level, held);
    end

    // reset while enabled mid-frame, R7, then seed reload R3
    en = 1'b1;
    repeat (7) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check(star_level == SEED, "R7 reset with en high", star_level, SEED);
    @(negedge clk);
    check(star_level == SEED, "R3 load at zero", star_level, SEED);
    @(negedge clk);
    check(star_level == 8'd236, "R1 first advance", star_level, 236);
    check(star_on == 1'b1, "R4 star at 236", star_on, 1);
    en = 1'b0;

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

endmodule